// File: doc/BRIEF.md
# Switch Port-Group Forwarding Resolver

This block turns the analyzer's per-frame forwarding facts into the set of egress ports for one received frame in a small Ethernet switch. Each lookup carries a MAC-table result (hit flag and the destination index stored in the matched entry), the frame class (unicast, multicast or broadcast) and the ingress port. From these the resolver reads a destination port-group mask and a per-source mask out of a host-writable table of port-group masks. It combines the two and reports a port mask plus a separate flag asking for a copy to the CPU port.

The CPU port gets special treatment. When a table-matched frame's destination group names the CPU port, the copy to the CPU is made whatever the source mask says. Flooded frames, which are sent when the MAC table misses, are always filtered by the source mask, and this includes the CPU bit. Software can therefore decide per ingress port whether unknown traffic reaches the CPU. Whitelisted addresses still reach the CPU whatever the source masks say.

The CPU port can be moved at run time with a single request. The block then walks every front port's source entry. In each entry it drops the old CPU bit and adds the new one, leaving the new CPU port's own source entry without the new bit. It then zeroes the new CPU port's own unicast group and points the CPU group entry at the new port alone.

Top module: `pg_fwd_resolver`

## Requirements
- R1: After reset every table entry is zero, the CPU port is port 11 and `outValid` is low, so any lookup returns an empty `outMask` and `outCpuCopy` low.
- R2: A lookup presented with `lkValid` high in a cycle yields `outValid` high with its result exactly two rising edges later. Back-to-back lookups are accepted every cycle. `outValid` is low in all other cycles.
- R3: A host write (`hostWe`, `hostIdx`, `hostData`) is stored at the rising edge where it is presented. A lookup in that same cycle sees the old entry and a lookup in the next cycle sees the new one. Writes with an index of 80 or more change nothing.
- R4: On a hit (`lkHit`=1) the destination mask is the table entry at `lkDestIdx`. An index of 80 or more reads as an empty mask.
- R5: On a miss the destination mask is a flood entry chosen by `lkClass`: code 0 (unicast) reads entry 60, code 1 (multicast) reads entry 61, and code 2 (broadcast) and the reserved code 3 read entry 62.
- R6: The source mask is table entry 68 plus `lkInPort`. Bit k of `outMask` (k not the CPU port) is set only when bit k is set in both the destination and the source mask.
- R7: `outCpuCopy` follows the CPU-port bit of the destination mask for hits and the AND of the destination and source CPU bits for misses. The CPU-port bit is never set in `outMask`.
- R8: The ingress port's own bit is always clear in `outMask`. When the ingress port is the CPU port, `outCpuCopy` is low.
- R9: A CPU-move request (`cpuMoveReq`, `cpuMovePort` < 12) finishes within 14 cycles. Each source entry 68+p loses the old CPU bit and, for p other than the new CPU port, gains the new one. Entry `cpuMovePort` becomes zero and entry 59 becomes the one-hot mask of the new port. Requests made while a move is under way, or naming a port of 12 or more, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host table write enable |
| hostIdx | input | 7 | Host table write index |
| hostData | input | 12 | Host table write data (port mask) |
| cpuMoveReq | input | 1 | Request to move the CPU port |
| cpuMovePort | input | 4 | New CPU port number |
| lkValid | input | 1 | Lookup valid |
| lkHit | input | 1 | MAC-table hit flag |
| lkDestIdx | input | 7 | Destination group index from the MAC entry |
| lkClass | input | 2 | Frame class: 0 unicast, 1 multicast, 2/3 broadcast |
| lkInPort | input | 4 | Ingress port number |
| outValid | output | 1 | Result valid |
| outMask | output | 12 | Egress port mask, CPU bit excluded |
| outCpuCopy | output | 1 | Copy the frame to the CPU port |

## Verification
Lookup results are due two rising edges after the lookup is driven. The bench drives on falling edges and checks on the falling edge that follows the second rising edge. In a back-to-back burst it also checks that `outValid` stays low for the first two samples. A host write is due at the first rising edge, so the bench sends a same-cycle lookup expecting the old entry and a next-cycle lookup expecting the new one. A CPU move needs at most 14 cycles, and the bench waits 16 before it sweeps all destination indices, frame classes and ingress ports again against its own table model.

// File: rtl/pg_fwd_pkg.sv
package pg_fwd_pkg;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_RSVD  = 2'd3
  } frame_class_e;

  typedef enum logic [1:0] {
    MV_IDLE   = 2'd0,
    MV_WALK   = 2'd1,
    MV_FINISH = 2'd2
  } move_state_e;

  // Strobes from the move sequencer to the table datapath.
  typedef struct packed {
    logic srcUpd;   // rewrite one source entry this cycle
    logic finish;   // clear new CPU unicast group, set CPU group
  } ctrl_strobe_t;

endpackage

// File: rtl/pg_fwd_ctrl.sv
module pg_fwd_ctrl
  import pg_fwd_pkg::*;
#(
  parameter int NumPorts     = 12,
  parameter int CpuResetPort = 11,
  localparam int PortW       = $clog2(NumPorts)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             moveReq,
  input  logic [PortW-1:0] movePort,
  output ctrl_strobe_t     strobe,
  output logic [PortW-1:0] walkPort,
  output logic [PortW-1:0] oldCpu,
  output logic [PortW-1:0] newCpu
);

  move_state_e      state;
  logic [PortW-1:0] walkIdx;
  logic [PortW-1:0] cpuPort;
  logic [PortW-1:0] targetCpu;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= MV_IDLE;
      walkIdx   <= '0;
      cpuPort   <= PortW'(CpuResetPort);
      targetCpu <= '0;
    end else begin
      unique case (state)
        MV_IDLE: begin
          if (moveReq && (32'(movePort) < NumPorts)) begin
            targetCpu <= movePort;
            walkIdx   <= '0;
            state     <= MV_WALK;
          end
        end
        MV_WALK: begin
          walkIdx <= walkIdx + 1'b1;
          if (32'(walkIdx) == NumPorts - 1) state <= MV_FINISH;
        end
        MV_FINISH: begin
          cpuPort <= targetCpu;
          state   <= MV_IDLE;
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.srcUpd = (state == MV_WALK);
    strobe.finish = (state == MV_FINISH);
  end

  assign walkPort = walkIdx;
  assign oldCpu   = cpuPort;
  assign newCpu   = targetCpu;

  // R9: the walk never addresses a port beyond the last front port
  assert_walk_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == MV_WALK) |-> (32'(walkIdx) < NumPorts));

  // R9: the finishing step commits the requested port as the CPU port
  assert_cpu_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (cpuPort == $past(targetCpu)));

endmodule

// File: rtl/pg_fwd_datapath.sv
module pg_fwd_datapath
  import pg_fwd_pkg::*;
#(
  parameter int NumPorts   = 12,
  parameter int TableDepth = 80,
  parameter int SrcBase    = 68,
  parameter int CpuGroup   = 59,
  parameter int FloodUc    = 60,
  parameter int FloodMc    = 61,
  parameter int FloodBc    = 62,
  localparam int PortW     = $clog2(NumPorts),
  localparam int IdxW      = $clog2(TableDepth)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [IdxW-1:0]     hostIdx,
  input  logic [NumPorts-1:0] hostData,
  input  logic                lkValid,
  input  logic                lkHit,
  input  logic [IdxW-1:0]     lkDestIdx,
  input  logic [1:0]          lkClass,
  input  logic [PortW-1:0]    lkInPort,
  input  ctrl_strobe_t        strobe,
  input  logic [PortW-1:0]    walkPort,
  input  logic [PortW-1:0]    oldCpu,
  input  logic [PortW-1:0]    newCpu,
  output logic                outValid,
  output logic [NumPorts-1:0] outMask,
  output logic                outCpuCopy
);

  logic [NumPorts-1:0] pgTable [TableDepth];

  function automatic logic [NumPorts-1:0] oneHot(input logic [PortW-1:0] p);
    return {{(NumPorts-1){1'b0}}, 1'b1} << p;
  endfunction

  function automatic logic [NumPorts-1:0] readEntry(input logic [31:0] idx);
    if (idx < 32'(TableDepth)) return pgTable[idx[IdxW-1:0]];
    return '0;
  endfunction

  // Table: host writes first, move strobes override on the same entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TableDepth; i++) pgTable[i] <= '0;
    end else begin
      if (hostWe && (32'(hostIdx) < TableDepth)) pgTable[hostIdx] <= hostData;
      if (strobe.srcUpd) begin
        pgTable[IdxW'(SrcBase) + IdxW'(walkPort)] <=
          (pgTable[IdxW'(SrcBase) + IdxW'(walkPort)] & ~oneHot(oldCpu)) |
          ((walkPort != newCpu) ? oneHot(newCpu) : '0);
      end
      if (strobe.finish) begin
        pgTable[IdxW'(newCpu)]   <= '0;
        pgTable[IdxW'(CpuGroup)] <= oneHot(newCpu);
      end
    end
  end

  // Stage 1: destination and source mask lookups.
  logic [31:0]         floodIdx;
  logic                s1Valid, s1Hit;
  logic [NumPorts-1:0] s1Dst, s1Src;
  logic [PortW-1:0]    s1InPort;

  always_comb begin
    unique case (frame_class_e'(lkClass))
      CLS_UCAST: floodIdx = 32'(FloodUc);
      CLS_MCAST: floodIdx = 32'(FloodMc);
      default:   floodIdx = 32'(FloodBc);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Hit    <= 1'b0;
      s1Dst    <= '0;
      s1Src    <= '0;
      s1InPort <= '0;
    end else begin
      s1Valid  <= lkValid;
      s1Hit    <= lkHit;
      s1Dst    <= lkHit ? readEntry(32'(lkDestIdx)) : readEntry(floodIdx);
      s1Src    <= readEntry(32'(SrcBase) + 32'(lkInPort));
      s1InPort <= lkInPort;
    end
  end

  // Stage 2: combine, CPU special case, hairpin removal.
  logic [NumPorts-1:0] cpuBit, masked, finalMask;
  logic                cpuSel;

  always_comb begin
    cpuBit    = oneHot(oldCpu);
    masked    = s1Dst & s1Src;
    cpuSel    = s1Hit ? |(s1Dst & cpuBit) : |(masked & cpuBit);
    finalMask = (masked & ~cpuBit) | (cpuSel ? cpuBit : '0);
    finalMask = finalMask & ~oneHot(s1InPort);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outMask    <= '0;
      outCpuCopy <= 1'b0;
    end else begin
      outValid   <= s1Valid;
      outMask    <= finalMask & ~cpuBit;
      outCpuCopy <= |(finalMask & cpuBit);
    end
  end

  // R3: an in-range host write with no competing move strobe lands next cycle
  assert_host_write_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && (32'(hostIdx) < TableDepth) && !strobe.srcUpd && !strobe.finish)
      |=> (pgTable[$past(hostIdx)] == $past(hostData)));

  // R8: a frame never leaves through the port it came in on
  assert_no_hairpin_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outMask & oneHot($past(s1InPort))) == '0));

  // R7: the CPU port never appears in the egress mask
  assert_cpu_not_in_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outMask & oneHot($past(oldCpu))) == '0));

  // R7: a hit whose destination group names the CPU bypasses the source mask
  assert_hit_cpu_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s1Hit && ((s1Dst & oneHot(oldCpu)) != '0) && (s1InPort != oldCpu))
      |=> outCpuCopy);

endmodule

// File: rtl/pg_fwd_resolver.sv
module pg_fwd_resolver
  import pg_fwd_pkg::*;
#(
  parameter int NumPorts     = 12,
  parameter int TableDepth   = 80,
  parameter int SrcBase      = 68,
  parameter int CpuGroup     = 59,
  parameter int FloodUc      = 60,
  parameter int FloodMc      = 61,
  parameter int FloodBc      = 62,
  parameter int CpuResetPort = 11,
  localparam int PortW       = $clog2(NumPorts),
  localparam int IdxW        = $clog2(TableDepth)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [IdxW-1:0]     hostIdx,
  input  logic [NumPorts-1:0] hostData,
  input  logic                cpuMoveReq,
  input  logic [PortW-1:0]    cpuMovePort,
  input  logic                lkValid,
  input  logic                lkHit,
  input  logic [IdxW-1:0]     lkDestIdx,
  input  logic [1:0]          lkClass,
  input  logic [PortW-1:0]    lkInPort,
  output logic                outValid,
  output logic [NumPorts-1:0] outMask,
  output logic                outCpuCopy
);

  ctrl_strobe_t     strobe;
  logic [PortW-1:0] walkPort, oldCpu, newCpu;

  pg_fwd_ctrl #(
    .NumPorts(NumPorts), .CpuResetPort(CpuResetPort)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .moveReq(cpuMoveReq), .movePort(cpuMovePort),
    .strobe(strobe), .walkPort(walkPort), .oldCpu(oldCpu), .newCpu(newCpu)
  );

  pg_fwd_datapath #(
    .NumPorts(NumPorts), .TableDepth(TableDepth), .SrcBase(SrcBase),
    .CpuGroup(CpuGroup), .FloodUc(FloodUc), .FloodMc(FloodMc), .FloodBc(FloodBc)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .hostWe(hostWe), .hostIdx(hostIdx), .hostData(hostData),
    .lkValid(lkValid), .lkHit(lkHit), .lkDestIdx(lkDestIdx),
    .lkClass(lkClass), .lkInPort(lkInPort),
    .strobe(strobe), .walkPort(walkPort), .oldCpu(oldCpu), .newCpu(newCpu),
    .outValid(outValid), .outMask(outMask), .outCpuCopy(outCpuCopy)
  );

endmodule

// File: tb/pg_fwd_resolver_tb.sv
module pg_fwd_resolver_tb_top;

  localparam int NP = 12, TD = 80, SRCB = 68, CPUG = 59;
  localparam int FUC = 60, FMC = 61, FBC = 62;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        hostWe = 1'b0, cpuMoveReq = 1'b0, lkValid = 1'b0, lkHit = 1'b0;
  logic [6:0]  hostIdx = '0, lkDestIdx = '0;
  logic [11:0] hostData = '0;
  logic [3:0]  cpuMovePort = '0, lkInPort = '0;
  logic [1:0]  lkClass = '0;
  logic        outValid, outCpuCopy;
  logic [11:0] outMask;

  pg_fwd_resolver dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostIdx(hostIdx), .hostData(hostData),
    .cpuMoveReq(cpuMoveReq), .cpuMovePort(cpuMovePort), .lkValid(lkValid),
    .lkHit(lkHit), .lkDestIdx(lkDestIdx), .lkClass(lkClass), .lkInPort(lkInPort),
    .outValid(outValid), .outMask(outMask), .outCpuCopy(outCpuCopy)
  );

  int checks = 0, errors = 0;
  logic [11:0] mdl [TD];
  int cpuM = 11;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [12:0] model(input logic hit, input int d, input int cls, input int p);
    logic [11:0] dst, src, fin;
    logic cb;
    int fi;
    fi  = (cls == 0) ? FUC : (cls == 1) ? FMC : FBC;
    dst = hit ? ((d < TD) ? mdl[d] : 12'h0) : mdl[fi];
    src = mdl[SRCB + p];
    fin = dst & src;
    cb  = hit ? dst[cpuM] : fin[cpuM];
    fin[cpuM] = cb;
    fin[p] = 1'b0;
    return {fin[cpuM], fin & ~(12'h1 << cpuM)};
  endfunction

  // Starts and ends just after a falling edge.
  task automatic lookup(input string req, input logic hit, input int d, input int cls, input int p);
    logic [12:0] e;
    e = model(hit, d, cls, p);
    lkValid = 1'b1; lkHit = hit; lkDestIdx = 7'(d); lkClass = 2'(cls); lkInPort = 4'(p);
    @(negedge clk); lkValid = 1'b0;
    @(negedge clk);
    chk(req, "valid", 32'(outValid), 32'd1);
    chk(req, $sformatf("mask hit=%0d d=%0d cls=%0d p=%0d", hit, d, cls, p), 32'(outMask), 32'(e[11:0]));
    chk(req, $sformatf("cpu hit=%0d d=%0d cls=%0d p=%0d", hit, d, cls, p), 32'(outCpuCopy), 32'(e[12]));
  endtask

  task automatic hostWrite(input int idx, input logic [11:0] data);
    hostWe = 1'b1; hostIdx = 7'(idx); hostData = data;
    @(negedge clk); hostWe = 1'b0;
    if (idx < TD) mdl[idx] = data;
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < NP; p++) begin
      for (int d = 0; d < TD; d++) lookup(req, 1'b1, d, 0, p);
      lookup(req, 1'b1, 100, 0, p);
      for (int c = 0; c < 4; c++) lookup(req, 1'b0, 0, c, p);
    end
  endtask

  task automatic moveCpu(input int np, input logic model_it);
    cpuMoveReq = 1'b1; cpuMovePort = 4'(np);
    @(negedge clk); cpuMoveReq = 1'b0;
    repeat (NP + 4) @(negedge clk);
    if (model_it) begin
      for (int p = 0; p < NP; p++) begin
        mdl[SRCB + p] &= ~(12'h1 << cpuM);
        if (p != np) mdl[SRCB + p] |= 12'h1 << np;
      end
      mdl[np] = '0;
      mdl[CPUG] = 12'h1 << np;
      cpuM = np;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [12:0] expQ [8];
    logic [12:0] eOld, eNew;
    for (int i = 0; i < TD; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", 32'(outValid), 32'd0);
    for (int p = 0; p < NP; p++) lookup("R1", 1'b1, p * 6, 0, p);
    for (int c = 0; c < 4; c++) lookup("R1", 1'b0, 0, c, 3);

    // R3: fill the table, including an out-of-range index that must be ignored
    for (int i = 0; i < TD; i++)
      hostWrite(i, ((i * 12'h9E3 + 12'h5A7) & 12'hFFF) | (12'h1 << (i % NP)));
    hostWrite(40, 12'hFFF);
    hostWrite(100, 12'h000);
    hostWrite(127, 12'h000);
    sweep("R4 R5 R6 R7 R8");

    // R3: same-cycle lookup sees old entry, next cycle sees new
    eOld = model(1'b1, 20, 0, 2);
    hostWe = 1'b1; hostIdx = 7'd20; hostData = 12'hA5A;
    lkValid = 1'b1; lkHit = 1'b1; lkDestIdx = 7'd20; lkClass = 2'd0; lkInPort = 4'd2;
    @(negedge clk);
    hostWe = 1'b0; mdl[20] = 12'hA5A;
    eNew = model(1'b1, 20, 0, 2);
    lkInPort = 4'd2;
    @(negedge clk); lkValid = 1'b0;
    chk("R3", "same-cycle old mask", 32'(outMask), 32'(eOld[11:0]));
    chk("R3", "same-cycle old cpu", 32'(outCpuCopy), 32'(eOld[12]));
    @(negedge clk);
    chk("R3", "next-cycle new mask", 32'(outMask), 32'(eNew[11:0]));
    chk("R3", "next-cycle new cpu", 32'(outCpuCopy), 32'(eNew[12]));

    // R2: back-to-back burst, results exactly two edges later
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k >= 2) begin
        chk("R2", "burst valid", 32'(outValid), 32'd1);
        chk("R2", "burst mask", 32'(outMask), 32'(expQ[k-2][11:0]));
        chk("R2", "burst cpu", 32'(outCpuCopy), 32'(expQ[k-2][12]));
      end else begin
        chk("R2", "burst leading valid", 32'(outValid), 32'd0);
      end
      if (k < 8) begin
        expQ[k] = model(k[0], 38 + k, k % 4, k + 3);
        lkValid = 1'b1; lkHit = k[0]; lkDestIdx = 7'(38 + k);
        lkClass = 2'(k % 4); lkInPort = 4'(k + 3);
      end else begin
        lkValid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R2", "valid after burst", 32'(outValid), 32'd0);

    // R9: move CPU 11 -> 3, then ignored requests, then 3 -> 0
    moveCpu(3, 1'b1);
    sweep("R9 R7 R8");
    moveCpu(13, 1'b0);
    cpuMoveReq = 1'b1; cpuMovePort = 4'd0;
    @(negedge clk); cpuMoveReq = 1'b0;
    @(negedge clk); cpuMoveReq = 1'b1; cpuMovePort = 4'd5;
    @(negedge clk); cpuMoveReq = 1'b0;
    repeat (NP + 4) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      mdl[SRCB + p] &= ~(12'h1 << cpuM);
      if (p != 0) mdl[SRCB + p] |= 12'h1;
    end
    mdl[0] = '0; mdl[CPUG] = 12'h1; cpuM = 0;
    sweep("R9 R6");
    lookup("R9", 1'b1, CPUG, 0, 7);
    lookup("R9", 1'b1, 0, 0, 7);
    finish_run();
  end

endmodule